// File: doc/BRIEF.md
# Sparse Activation Scanner and Broadcaster

This block holds one vector of input activations, split into equal contiguous slices, one per processing-element slice. It walks the vector from the lowest index upward and presents only the non-zero entries, one at a time, on a broadcast port. Each broadcast carries the activation value and its global position, so every processing element receives the same pair in the same cycle. Zero entries never use a broadcast cycle.

Each slice finds its own lowest-indexed pending non-zero entry. A binary tree of merge nodes then combines these local candidates in pairs, up to a single root, to pick the lowest global index. A broadcast completes when `bc_valid` and `bc_ready` are both high at a rising edge. The consumed entry is then retired, and the next candidate appears in the following cycle. `done` is high whenever no non-zero entry is pending.

A new vector is written in a single cycle through the load port. A load replaces any scan that is still in progress.

Top module: `act_nz_broadcaster`

## Requirements
- R1: After reset `bc_valid` is 0 and `done` is 1.
- R2: With `load_en` high at a rising edge, the block captures `load_vec`, and activation i sits in bits [i*DATA_W +: DATA_W]. The new contents decide the outputs from the next cycle on. A load discards whatever was still pending from the earlier vector.
- R3: While `bc_valid` is high, `bc_data` is never zero.
- R4: Non-zero activations are presented in strictly ascending index order. `bc_index` is the activation's position i, and `bc_data` is its value.
- R5: With `bc_ready` held high, a vector holding K non-zero entries is drained in exactly K cycles. Zero entries, including those at slice boundaries, add no cycles.
- R6: While `bc_valid` is high and `bc_ready` is low, and no load occurs, `bc_valid`, `bc_data` and `bc_index` keep their values into the next cycle.
- R7: `done` is high exactly when no non-zero entry is pending, and `done` and `bc_valid` are never high together.
- R8: Loading an all-zero vector leaves `done` high and never raises `bc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Capture `load_vec` at this edge |
| load_vec | input | N_SLICES*SLICE_LEN*DATA_W | Full activation vector, entry i in bits [i*DATA_W +: DATA_W] |
| bc_valid | output | 1 | A non-zero activation is being broadcast |
| bc_ready | input | 1 | Processing elements accept the broadcast |
| bc_data | output | DATA_W | Broadcast activation value |
| bc_index | output | clog2(N_SLICES*SLICE_LEN) | Global position of the broadcast activation |
| done | output | 1 | No non-zero activation remains pending |

## Verification
The broadcast outputs and `done` are driven combinationally from the slice registers. A load or an accepted broadcast at a rising edge is therefore visible in the cycle that follows, one register stage later. The bench drives inputs and samples outputs at the falling edge. At each falling edge it compares the outputs against a behavioural model of the pending entries, which has been advanced by exactly the inputs applied at the previous rising edge. Hold behaviour and drain length are also checked against values recorded in earlier cycles.

// File: rtl/nzd_pkg.sv
package nzd_pkg;
    localparam int NZD_DEF_SLICES    = 4;
    localparam int NZD_DEF_SLICE_LEN = 4;
    localparam int NZD_DEF_DATA_W    = 8;

    function automatic int nzd_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/nzd_slice.sv
module nzd_slice #(
    parameter int SLICE_LEN = 4,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 4,
    parameter int SLICE_ID  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [SLICE_LEN*DATA_W-1:0] load_slice,
    input  logic                        clr_en,
    input  logic [nzd_pkg::nzd_bits(SLICE_LEN)-1:0] clr_loc,
    output logic                        cand_vld,
    output logic [IDX_W-1:0]            cand_idx,
    output logic [DATA_W-1:0]           cand_val
);
    localparam int LOC_W = nzd_pkg::nzd_bits(SLICE_LEN);
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(SLICE_ID * SLICE_LEN);

    typedef struct packed {
        logic [SLICE_LEN-1:0]             vld;
        logic [SLICE_LEN-1:0][DATA_W-1:0] val;
    } slc_st_t;

    slc_st_t st_d, st_q;
    logic [LOC_W-1:0] loc;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            for (int i = 0; i < SLICE_LEN; i++) begin
                st_d.val[i] = load_slice[i*DATA_W +: DATA_W];
                st_d.vld[i] = |load_slice[i*DATA_W +: DATA_W];
            end
        end else if (clr_en) begin
            st_d.vld[clr_loc] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        loc = '0;
        for (int i = SLICE_LEN - 1; i >= 0; i--) begin
            if (st_q.vld[i]) loc = i[LOC_W-1:0];
        end
        cand_vld = |st_q.vld;
        cand_val = st_q.val[loc];
        cand_idx = BASE_IDX + IDX_W'(loc);
    end
endmodule

// File: rtl/nzd_merge.sv
module nzd_merge #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              lo_vld,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [DATA_W-1:0] lo_val,
    input  logic              hi_vld,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic [DATA_W-1:0] hi_val,
    output logic              out_vld,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_val
);
    logic take_hi;

    always_comb begin
        take_hi = hi_vld && (!lo_vld || (hi_idx < lo_idx));
        out_vld = lo_vld | hi_vld;
        out_idx = take_hi ? hi_idx : lo_idx;
        out_val = take_hi ? hi_val : lo_val;
    end
endmodule

// File: rtl/nzd_tree.sv
module nzd_tree #(
    parameter int N_LEAF = 4,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic [N_LEAF-1:0]             leaf_vld,
    input  logic [N_LEAF-1:0][IDX_W-1:0]  leaf_idx,
    input  logic [N_LEAF-1:0][DATA_W-1:0] leaf_val,
    output logic                          root_vld,
    output logic [IDX_W-1:0]              root_idx,
    output logic [DATA_W-1:0]             root_val
);
    localparam int NODES = 2 * N_LEAF - 1;

    logic [NODES-1:0]             nd_vld;
    logic [NODES-1:0][IDX_W-1:0]  nd_idx;
    logic [NODES-1:0][DATA_W-1:0] nd_val;

    for (genvar s = 0; s < N_LEAF; s++) begin : g_leaf
        assign nd_vld[N_LEAF-1+s] = leaf_vld[s];
        assign nd_idx[N_LEAF-1+s] = leaf_idx[s];
        assign nd_val[N_LEAF-1+s] = leaf_val[s];
    end

    for (genvar k = 0; k < N_LEAF - 1; k++) begin : g_node
        nzd_merge #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_merge (
            .lo_vld (nd_vld[2*k+1]),
            .lo_idx (nd_idx[2*k+1]),
            .lo_val (nd_val[2*k+1]),
            .hi_vld (nd_vld[2*k+2]),
            .hi_idx (nd_idx[2*k+2]),
            .hi_val (nd_val[2*k+2]),
            .out_vld(nd_vld[k]),
            .out_idx(nd_idx[k]),
            .out_val(nd_val[k])
        );
    end

    assign root_vld = nd_vld[0];
    assign root_idx = nd_idx[0];
    assign root_val = nd_val[0];
endmodule

// File: rtl/act_nz_broadcaster.sv
module act_nz_broadcaster #(
    parameter int N_SLICES  = nzd_pkg::NZD_DEF_SLICES,
    parameter int SLICE_LEN = nzd_pkg::NZD_DEF_SLICE_LEN,
    parameter int DATA_W    = nzd_pkg::NZD_DEF_DATA_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_en,
    input  logic [N_SLICES*SLICE_LEN*DATA_W-1:0]  load_vec,
    output logic                                  bc_valid,
    input  logic                                  bc_ready,
    output logic [DATA_W-1:0]                     bc_data,
    output logic [$clog2(N_SLICES*SLICE_LEN)-1:0] bc_index,
    output logic                                  done
);
    localparam int N_ACT   = N_SLICES * SLICE_LEN;
    localparam int IDX_W   = $clog2(N_ACT);
    localparam int LOC_W   = nzd_pkg::nzd_bits(SLICE_LEN);
    localparam int SEL_W   = IDX_W - LOC_W;
    localparam int SLICE_W = SLICE_LEN * DATA_W;

    logic [N_SLICES-1:0]             c_vld;
    logic [N_SLICES-1:0][IDX_W-1:0]  c_idx;
    logic [N_SLICES-1:0][DATA_W-1:0] c_val;
    logic                            accept;
    logic [SEL_W-1:0]                hit_slice;
    logic [LOC_W-1:0]                hit_loc;

    assign accept    = bc_valid & bc_ready;
    assign hit_slice = bc_index[IDX_W-1:LOC_W];
    assign hit_loc   = bc_index[LOC_W-1:0];

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        logic clr_here;
        assign clr_here = accept && (hit_slice == SEL_W'(s));
        nzd_slice #(
            .SLICE_LEN(SLICE_LEN), .DATA_W(DATA_W), .IDX_W(IDX_W), .SLICE_ID(s)
        ) i_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en),
            .load_slice(load_vec[s*SLICE_W +: SLICE_W]),
            .clr_en    (clr_here),
            .clr_loc   (hit_loc),
            .cand_vld  (c_vld[s]),
            .cand_idx  (c_idx[s]),
            .cand_val  (c_val[s])
        );
    end

    nzd_tree #(.N_LEAF(N_SLICES), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_tree (
        .leaf_vld(c_vld),
        .leaf_idx(c_idx),
        .leaf_val(c_val),
        .root_vld(bc_valid),
        .root_idx(bc_index),
        .root_val(bc_data)
    );

    assign done = ~|c_vld;
endmodule

// File: rtl/nzd_checker.sv
module nzd_checker #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8,
    parameter int VEC_W  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [VEC_W-1:0]  load_vec,
    input logic              bc_valid,
    input logic              bc_ready,
    input logic [DATA_W-1:0] bc_data,
    input logic [IDX_W-1:0]  bc_index,
    input logic              done
);
    assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (bc_data != '0));

    assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_ready && !load_en) |=> (!bc_valid || (bc_index > $past(bc_index))));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !bc_ready && !load_en) |=>
            (bc_valid && $stable(bc_data) && $stable(bc_index)));

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done != bc_valid);

    assert_zero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (load_vec == '0)) |=> (done && !bc_valid));
endmodule

bind act_nz_broadcaster nzd_checker #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .VEC_W(N_ACT*DATA_W)
) i_nzd_checker (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_vec(load_vec),
    .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_data(bc_data),
    .bc_index(bc_index), .done(done)
);

// File: tb/test_act_nz_broadcaster.sv
module test_act_nz_broadcaster;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int SL = 4;
    localparam int DW = 8;
    localparam int NA = NS * SL;
    localparam int IW = $clog2(NA);
    localparam int VW = NA * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [VW-1:0] load_vec = '0;
    logic          bc_valid;
    logic          bc_ready = 1'b0;
    logic [DW-1:0] bc_data;
    logic [IW-1:0] bc_index;
    logic          done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int mdl[NA];
    bit hold_pend = 0;
    logic [DW-1:0] hold_data;
    logic [IW-1:0] hold_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    act_nz_broadcaster #(.N_SLICES(NS), .SLICE_LEN(SL), .DATA_W(DW)) i_act_nz_broadcaster (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_vec(load_vec),
        .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_data(bc_data),
        .bc_index(bc_index), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int first_nz();
        for (int i = 0; i < NA; i++) if (mdl[i] != 0) return i;
        return -1;
    endfunction

    // Called just after a falling edge: compare, drive, advance the model.
    task automatic tick(input logic ld, input logic [VW-1:0] vec, input logic rdy);
        int f;
        f = first_nz();
        chk(bc_valid == (f >= 0), "R7 bc_valid", bc_valid, f >= 0);
        chk(done == (f < 0), "R7 done", done, f < 0);
        if (f >= 0) begin
            chk(bc_index == IW'(f), "R4 bc_index", bc_index, f);
            chk(bc_data == DW'(mdl[f]), "R4 bc_data", bc_data, mdl[f]);
        end
        if (bc_valid) chk(bc_data != 0, "R3 nonzero", bc_data, 1);
        if (hold_pend) begin
            chk(bc_valid && bc_data == hold_data && bc_index == hold_idx,
                "R6 hold", bc_index, hold_idx);
        end
        hold_pend = bc_valid && !rdy && !ld;
        hold_data = bc_data;
        hold_idx  = bc_index;
        load_en = ld; load_vec = vec; bc_ready = rdy;
        if (ld) begin
            for (int i = 0; i < NA; i++) mdl[i] = int'(vec[i*DW +: DW]);
        end else if (f >= 0 && rdy) begin
            mdl[f] = 0;
        end
        @(negedge clk);
        cyc++;
    endtask

    function automatic logic [VW-1:0] rand_vec(input int pct);
        logic [VW-1:0] v = '0;
        for (int i = 0; i < NA; i++)
            if (int'($urandom % 100) < pct) v[i*DW +: DW] = DW'($urandom % 255 + 1);
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [VW-1:0] v;
        int nz, cnt;
        for (int i = 0; i < NA; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(bc_valid == 1'b0, "R1 bc_valid", bc_valid, 0);
        chk(done == 1'b1, "R1 done", done, 1);

        // R8: all-zero vector
        tick(1'b1, '0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk(!bc_valid && done, "R8 zero vector", bc_valid, 0);
            tick(1'b0, '0, 1'b1);
        end

        // R5: directed sparse vector across slice boundaries, drained with ready high
        v = '0;
        v[0*DW +: DW] = 8'd5; v[3*DW +: DW] = 8'd9; v[4*DW +: DW] = 8'd200; v[15*DW +: DW] = 8'd1;
        tick(1'b1, v, 1'b1);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            if (!done) cnt++;
            tick(1'b0, '0, 1'b1);
        end
        chk(cnt == 4, "R5 drain cycles", cnt, 4);

        // R6: ready low holds the output
        v = '0; v[6*DW +: DW] = 8'd7; v[10*DW +: DW] = 8'd3;
        tick(1'b1, v, 1'b0);
        for (int k = 0; k < 3; k++) tick(1'b0, '0, 1'b0);
        for (int k = 0; k < 4; k++) tick(1'b0, '0, 1'b1);

        // R2: load in the middle of a scan replaces pending entries
        tick(1'b1, rand_vec(60), 1'b1);
        tick(1'b0, '0, 1'b1);
        v = '0; v[2*DW +: DW] = 8'd44;
        tick(1'b1, v, 1'b1);
        chk(bc_valid && bc_index == 2 && bc_data == 44, "R2 reload", bc_index, 2);
        tick(1'b0, '0, 1'b1);
        chk(done, "R2 old entries discarded", done, 1);

        // Random traffic, ready toggling, occasional reloads (R4, R5, R6, R7)
        for (int r = 0; r < 12; r++) begin
            v = rand_vec(20 + 6 * r);
            nz = 0;
            for (int i = 0; i < NA; i++) if (v[i*DW +: DW] != 0) nz++;
            tick(1'b1, v, 1'b1);
            cnt = 0;
            for (int k = 0; k < 40; k++) begin
                if (!done) cnt++;
                tick(1'b0, '0, 1'b1);
            end
            chk(cnt == nz, "R5 random drain", cnt, nz);
            tick(1'b1, rand_vec(40), 1'b0);
            for (int k = 0; k < 50; k++)
                tick(($urandom % 23) == 0 ? 1'b1 : 1'b0, rand_vec(35), 1'($urandom % 2));
        end
        tick(1'b0, '0, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule